// File: doc/BRIEF.md
# Power-Loss Record Save Controller

This block protects an accumulated 24-bit meter record across a loss of supply. Once the start-up logic has confirmed that the supply is healthy and the memory is usable, it raises the arm input. The controller then watches a supply-good level that has already been synchronized to its clock. When that level falls, the controller does not act at once. It runs a filter wait of fixed length, sized to outlast a typical mains sag, and keeps the external watchdog alive while it waits. At the end of the wait it samples the supply again. If the supply has recovered, the event was a sag and the controller returns to idle without touching memory.

If the supply is still down, the controller captures the record and stores it three times, as nine single-byte writes to consecutive nonvolatile addresses. A separate serial memory engine carries out each write. After the ninth write the controller enters a terminal park state. It stops kicking the watchdog and waits for the supply to collapse. Only a reset brings it out of park. The filter length, the per-byte time limit and the kick period are all cycle-count parameters.

Top module: `pfsave_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy_o, saved_o, wr_req_o and kick_o are all 0.
- R2: Before arming, a falling supply_ok_i is ignored: busy_o stays 0 and no write is requested. A single-cycle pulse on arm_i arms the block permanently until the next reset.
- R3: When the block is armed and idle, the first rising edge that samples supply_ok_i at 0 after it was 1 raises busy_o. supply_ok_i is then sampled again on the FILTER_CYC-th rising edge after that one. A sag that lasts FILTER_CYC edges or fewer therefore counts as recovered, and a sag of FILTER_CYC+1 edges causes a save.
- R4: If supply_ok_i is 1 at the decision edge, the block returns to idle with busy_o=0 and saved_o=0 and issues no write.
- R5: If supply_ok_i is 0 at the decision edge, the block issues exactly 9 byte writes to addresses BASE_ADDR+0 to BASE_ADDR+8, one per address in increasing order. The write to BASE_ADDR+3c+b carries record bits [8b+7:8b], for copy c in 0..2 and byte b in 0..2.
- R6: The record is captured on the decision edge. A change on record_i after that edge does not change any of the three stored copies.
- R7: Only one write is outstanding at a time. wr_addr_o and wr_data_o are held stable while wr_req_o is high, and wr_req_o is low for at least one cycle after each edge on which wr_done_i is seen.
- R8: If wr_done_i does not arrive within WR_TMO_CYC cycles of request, the block drops that byte and moves on to the next address. The sequence still ends after 9 requests.
- R9: After the last write, saved_o is 1 and busy_o is 0 until reset. Later supply rises and falls start no new writes.
- R10: kick_o toggles every KICK_CYC cycles in every state except park, including the filter wait. In park kick_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arming pulse from the start-up check (sticky) |
| supply_ok_i | input | 1 | Synchronized supply-good level |
| record_i | input | 24 | Live accumulated record |
| wr_req_o | output | 1 | Byte write request to the memory engine |
| wr_addr_o | output | ADDR_W | Byte address of the current write |
| wr_data_o | output | 8 | Byte value of the current write |
| wr_done_i | input | 1 | One-cycle completion pulse from the memory engine |
| kick_o | output | 1 | Watchdog service toggle |
| busy_o | output | 1 | Filter wait or save in progress |
| saved_o | output | 1 | All copies issued; block is parked |

## Verification
The assertions assume that wr_done_i is a single-cycle pulse that arrives only while wr_req_o is high, and that supply_ok_i is already synchronous to clk. The bench models the memory engine so that it meets both assumptions. It captures a request at the falling edge after the request appears, and it returns done after a fixed latency only while that request is still high. For the no-response case it never returns done, and it releases the request once the controller drops it. Every bench input changes on the falling clock edge, so no input changes near the sampling edge.

// File: rtl/pfsave_pkg.sv
package pfsave_pkg;

  localparam int unsigned REC_BYTES  = 3;
  localparam int unsigned REC_COPIES = 3;
  localparam int unsigned REC_W      = 8 * REC_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FILTER = 3'd1,
    ST_WRITE  = 3'd2,
    ST_NEXT   = 3'd3,
    ST_PARK   = 3'd4
  } pf_state_e;

endpackage

// File: rtl/pfsave_timer.sv
// Saturating cycle counter; expired is high on the LIMIT-th enabled cycle.
module pfsave_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_we;

  assign expired = (cnt_q == W'(LIMIT - 1));
  assign cnt_we  = clr | (en & ~expired);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pfsave_kick.sv
// Watchdog service: toggles every PERIOD cycles while run is high.
module pfsave_kick #(
  parameter int unsigned PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic kick
);

  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;
  logic         kick_q, kick_d;

  assign wrap = (cnt_q == W'(PERIOD - 1));

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + W'(1);
    kick_d = wrap ? ~kick_q : kick_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      kick_q <= 1'b0;
    end else if (run) begin
      cnt_q  <= cnt_d;
      kick_q <= kick_d;
    end
  end

  assign kick = kick_q;

endmodule

// File: rtl/pfsave_seq.sv
// Holds the captured record and walks copy-major byte addresses.
module pfsave_seq
  import pfsave_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic              step,
  input  logic [REC_W-1:0]  rec_in,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data,
  output logic              last
);

  localparam int unsigned TOTAL = REC_BYTES * REC_COPIES;
  localparam int unsigned IW    = $clog2(TOTAL + 1);
  localparam int unsigned BW    = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1;

  logic [REC_W-1:0] rec_q, rec_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [BW-1:0]    byte_q, byte_d;
  logic             we;
  logic [7:0]       lane [REC_BYTES];

  for (genvar g = 0; g < REC_BYTES; g++) begin : g_lane
    assign lane[g] = rec_q[8*g +: 8];
  end

  assign we = latch | step;

  always_comb begin
    if (latch) begin
      rec_d  = rec_in;
      idx_d  = '0;
      byte_d = '0;
    end else begin
      rec_d  = rec_q;
      idx_d  = idx_q + IW'(1);
      byte_d = (byte_q == BW'(REC_BYTES - 1)) ? '0 : byte_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= '0;
      idx_q  <= '0;
      byte_q <= '0;
    end else if (we) begin
      rec_q  <= rec_d;
      idx_q  <= idx_d;
      byte_q <= byte_d;
    end
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < REC_BYTES; i++) begin
      if (byte_q == BW'(i)) data = lane[i];
    end
  end

  assign addr = ADDR_W'(BASE_ADDR) + ADDR_W'(idx_q);
  assign last = (idx_q == IW'(TOTAL - 1));

endmodule

// File: rtl/pfsave_ctrl.sv
module pfsave_ctrl
  import pfsave_pkg::*;
#(
  parameter int unsigned FILTER_CYC = 15_000_000,
  parameter int unsigned WR_TMO_CYC = 250_000,
  parameter int unsigned KICK_CYC   = 500_000,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BASE_ADDR  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              supply_ok_i,
  input  logic [23:0]       record_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  input  logic              wr_done_i,
  output logic              kick_o,
  output logic              busy_o,
  output logic              saved_o
);

  pf_state_e state_q, state_d;
  logic      armed_q, sup_q;
  logic      fall;
  logic      filt_clr, filt_en, filt_exp;
  logic      tmo_clr, tmo_en, tmo_exp;
  logic      seq_latch, seq_step, seq_last;

  // Edge detect on the supply level; sup_q resets low so no false edge (R3)
  assign fall = armed_q & sup_q & ~supply_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      sup_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sup_q   <= supply_ok_i;
      if (arm_i) armed_q <= 1'b1;   // sticky arm (R2)
    end
  end

  always_comb begin
    state_d   = state_q;
    filt_clr  = 1'b0;
    filt_en   = 1'b0;
    seq_latch = 1'b0;
    seq_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        filt_clr = 1'b1;
        if (fall) state_d = ST_FILTER;
      end
      ST_FILTER: begin
        filt_en = 1'b1;
        if (filt_exp) begin
          if (supply_ok_i) begin
            state_d = ST_IDLE;              // sag rode through (R4)
          end else begin
            state_d   = ST_WRITE;
            seq_latch = 1'b1;               // capture record (R6)
          end
        end
      end
      ST_WRITE: begin
        if (wr_done_i || tmo_exp) begin     // R7, R8
          if (seq_last) begin
            state_d = ST_PARK;
          end else begin
            seq_step = 1'b1;
            state_d  = ST_NEXT;
          end
        end
      end
      ST_NEXT:  state_d = ST_WRITE;
      ST_PARK:  state_d = ST_PARK;          // terminal (R9)
      default:  state_d = ST_IDLE;
    endcase
  end

  assign tmo_clr = (state_q != ST_WRITE);
  assign tmo_en  = (state_q == ST_WRITE);

  pfsave_timer #(.LIMIT(FILTER_CYC)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (filt_clr),
    .en      (filt_en),
    .expired (filt_exp)
  );

  pfsave_timer #(.LIMIT(WR_TMO_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmo_clr),
    .en      (tmo_en),
    .expired (tmo_exp)
  );

  pfsave_seq #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .latch  (seq_latch),
    .step   (seq_step),
    .rec_in (record_i),
    .addr   (wr_addr_o),
    .data   (wr_data_o),
    .last   (seq_last)
  );

  pfsave_kick #(.PERIOD(KICK_CYC)) u_kick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q != ST_PARK),        // R10
    .kick  (kick_o)
  );

  assign wr_req_o = (state_q == ST_WRITE);
  assign busy_o   = (state_q == ST_FILTER) || (state_q == ST_WRITE) || (state_q == ST_NEXT);
  assign saved_o  = (state_q == ST_PARK);

endmodule

// File: rtl/pfsave_chk.sv
module pfsave_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [7:0]        wr_data_o,
  input logic              wr_done_i,
  input logic              kick_o,
  input logic              busy_o,
  input logic              saved_o
);

  p_req_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> busy_o);

  p_hold_addr_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && $past(wr_req_o)) |-> ($stable(wr_addr_o) && $stable(wr_data_o)));

  p_gap_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_done_i) |=> !wr_req_o);

  p_addr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> ((wr_addr_o >= ADDR_W'(BASE_ADDR)) && (wr_addr_o < ADDR_W'(BASE_ADDR + 9))));

  p_saved_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    saved_o |=> (saved_o && !busy_o));

  p_park_kick_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    saved_o |=> $stable(kick_o));

endmodule

bind pfsave_ctrl pfsave_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_req_o  (wr_req_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .wr_done_i (wr_done_i),
  .kick_o    (kick_o),
  .busy_o    (busy_o),
  .saved_o   (saved_o)
);

// File: tb/pfsave_ctrl_test.sv
module pfsave_ctrl_test;

  localparam int F    = 20;
  localparam int T    = 16;
  localparam int K    = 4;
  localparam int BASE = 16;
  localparam int NVEC = 5;

  typedef struct packed {
    logic [23:0] rec;
    logic [7:0]  sag;   // 255 = never recovers
    logic [7:0]  lat;   // 0 = engine never answers
    logic [7:0]  nwr;   // expected writes
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{rec: 24'h123456, sag: 8'd5,   lat: 8'd3, nwr: 8'd0},
    '{rec: 24'hA5C3F0, sag: 8'd20,  lat: 8'd3, nwr: 8'd0},
    '{rec: 24'h55AA01, sag: 8'd21,  lat: 8'd3, nwr: 8'd9},
    '{rec: 24'hFFFFFF, sag: 8'd255, lat: 8'd7, nwr: 8'd9},
    '{rec: 24'h000102, sag: 8'd255, lat: 8'd0, nwr: 8'd9}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, arm, sup, done;
  logic [23:0] rec;
  logic        wr_req, kick, busy, saved;
  logic [7:0]  waddr, wdata;

  pfsave_ctrl #(
    .FILTER_CYC(F), .WR_TMO_CYC(T), .KICK_CYC(K), .ADDR_W(8), .BASE_ADDR(BASE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .supply_ok_i(sup), .record_i(rec),
    .wr_req_o(wr_req), .wr_addr_o(waddr), .wr_data_o(wdata), .wr_done_i(done),
    .kick_o(kick), .busy_o(busy), .saved_o(saved)
  );

  int checks = 0, fails = 0, cyc = 0;
  int lat_cfg, wcnt, eng_cnt, kick_tog, proto_err;
  bit eng_busy, busy_seen, done_prev, req_prev;
  logic [7:0] cap_a [16];
  logic [7:0] cap_d [16];
  logic [7:0] a_prev, d_prev;
  logic kick_prev;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // One clock: wait for falling edge, observe outputs, model the memory engine.
  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
    if (done_prev && wr_req) proto_err++;
    if (wr_req && req_prev && (waddr != a_prev || wdata != d_prev)) proto_err++;
    if (kick !== kick_prev) kick_tog++;
    if (busy) busy_seen = 1;
    kick_prev = kick; req_prev = wr_req; a_prev = waddr; d_prev = wdata;
    done = 1'b0;
    if (eng_busy && !wr_req) begin
      eng_busy = 0;
    end else if (eng_busy) begin
      eng_cnt++;
      if (lat_cfg != 0 && eng_cnt >= lat_cfg) begin
        done = 1'b1;
        eng_busy = 0;
      end
    end else if (wr_req) begin
      if (wcnt < 16) begin
        cap_a[wcnt] = waddr;
        cap_d[wcnt] = wdata;
      end
      wcnt++;
      eng_busy = 1;
      eng_cnt = 0;
    end
    done_prev = done;
  endtask

  task automatic do_reset(input int lat);
    rst_n = 1'b0; arm = 1'b0; sup = 1'b1; done = 1'b0; rec = '0;
    lat_cfg = lat; wcnt = 0; eng_busy = 0; proto_err = 0;
    done_prev = 0; req_prev = 0; busy_seen = 0;
    repeat (3) cycle();
    // R1: outputs idle while reset held
    chk(!busy && !saved && !wr_req && !kick, "R1 in reset", {busy, saved, wr_req, kick}, 0);
    rst_n = 1'b1;
    cycle();
    chk(!busy && !saved && !wr_req && !kick, "R1 after release", {busy, saved, wr_req, kick}, 0);
    kick_prev = kick;
  endtask

  task automatic arm_pulse();
    arm = 1'b1;
    cycle();
    arm = 1'b0;
    repeat (3) cycle();
  endtask

  initial begin
    rst_n = 1'b0; arm = 1'b0; sup = 1'b1; done = 1'b0; rec = '0;
    kick_prev = 1'b0; a_prev = '0; d_prev = '0;

    // Table walk: each vector is a sag of given length with an engine latency.
    for (int v = 0; v < NVEC; v++) begin
      do_reset(int'(VEC[v].lat));
      rec = VEC[v].rec;
      arm_pulse();
      sup = 1'b0;
      for (int c = 0; c < 400; c++) begin
        if (VEC[v].sag != 8'd255 && c == int'(VEC[v].sag)) sup = 1'b1;
        if (c == F + 3) rec = ~VEC[v].rec;  // R6: change after decision
        if (c == 1) kick_tog = 0;
        if (c == 5) chk(busy == 1'b1, "R3 busy during filter", busy, 1);
        if (c == F) chk(kick_tog >= 4, "R10 kick toggles in filter", kick_tog, 4);
        cycle();
      end
      chk(wcnt == int'(VEC[v].nwr), (VEC[v].nwr == 0) ? "R4 no writes after recovery"
                                                     : "R5 write count", wcnt, VEC[v].nwr);
      chk(proto_err == 0, "R7 handshake order", proto_err, 0);
      if (VEC[v].nwr != 0) begin
        for (int i = 0; i < 9; i++) begin
          chk(cap_a[i] == 8'(BASE + i), "R5 address", cap_a[i], BASE + i);
          chk(cap_d[i] == VEC[v].rec[8*(i%3) +: 8],
              (VEC[v].lat == 0) ? "R8 data after timeouts" : "R6 data copy",
              cap_d[i], VEC[v].rec[8*(i%3) +: 8]);
        end
        chk(saved && !busy, "R9 parked", {saved, busy}, 2);
      end else begin
        chk(!saved && !busy, "R4 back to idle", {saved, busy}, 0);
      end
    end

    // R2: unarmed block ignores a supply drop
    do_reset(3);
    sup = 1'b0;
    repeat (60) cycle();
    chk(!busy_seen, "R2 unarmed busy", busy_seen, 0);
    chk(wcnt == 0, "R2 unarmed writes", wcnt, 0);
    // R2: a single arm pulse stays in force
    sup = 1'b1;
    arm_pulse();
    repeat (10) cycle();
    sup = 1'b0;
    repeat (5) cycle();
    chk(busy == 1'b1, "R2 sticky arm", busy, 1);

    // R9, R10: park is permanent and kick freezes there
    repeat (300) cycle();
    chk(saved == 1'b1 && wcnt == 9, "R9 save done", wcnt, 9);
    kick_tog = 0;
    sup = 1'b1;
    repeat (20) cycle();
    sup = 1'b0;
    repeat (300) cycle();
    chk(wcnt == 9, "R9 no new writes in park", wcnt, 9);
    chk(saved && !busy, "R9 still parked", {saved, busy}, 2);
    chk(kick_tog == 0, "R10 kick frozen in park", kick_tog, 0);

    finish_run();
  end

endmodule